// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Device

This block models a combinational programmable logic device. A programmable AND plane forms product terms from 16 array variables, each available in true and complemented form. A fixed OR plane then combines the terms. Each of the 8 outputs owns a private group of 8 product terms. Seven of them are ORed and the result is inverted onto the output value. The eighth term gates the output's tri-state enable. The 16 array variables come from 10 dedicated inputs and from the pin values of the first 6 outputs. Those 6 outputs are bidirectional, so they can be used as extra inputs, as helper terms, or as feedback loops that hold state.

The connection pattern is a 2048-bit map, held in a register and written one bit per transfer through a serial configuration stream. The stream is valid/ready. A bit moves only in a cycle where `cfg_valid` and `cfg_ready` are both high. `cfg_ready` is low during reset and high from the first clock after it, so the block never applies back-pressure after reset. The sender may hold `cfg_valid` low for any number of cycles between bits.

The array variables are captured in a register once per clock. A change on the dedicated inputs therefore reaches the outputs after the next rising edge. Each trip around a feedback path adds one more clock.

Top module: `prog_sop_device`

## Requirements
- R1: Map bit `row*32 + 2*v` connects the true literal of variable v to product row `row`, and bit `row*32 + 2*v + 1` connects its complement. Variables 0 to 9 are `ded_in[0]` to `ded_in[9]`, and variables 10 to 15 are the pin values of outputs 0 to 5.
- R2: Map bits are taken in ascending index order, one per cycle with `cfg_valid && cfg_ready`. Cycles with `cfg_valid` low consume nothing. After index 2047 the next bit goes to index 0.
- R3: `cfg_ready` is low while `rst_n` is low and high from the first rising edge after reset is released.
- R4: A product row with no connected literal evaluates to 1. A row connected to both literals of any variable evaluates to 0.
- R5: For output i, `out_val[i]` is the inverse of the OR of rows 8i to 8i+6.
- R6: `out_oe[i]` equals product row 8i+7. `out_val[i]` is meaningful only while `out_oe[i]` is 1; a 0 enable means the pin is high impedance.
- R7: The pin value of output i (i < 6) is `out_val[i]` while `out_oe[i]` is 1, and `io_in[i]` otherwise. While the output is enabled, `io_in[i]` has no effect.
- R8: Array variables are sampled on each rising edge. An input change reaches a feedback-free output after exactly one edge, and each pass around a feedback path takes one further edge.
- R9: Reset clears the whole map, so after reset every output is enabled and drives 0.
- R10: Product rows are never shared. An output's OR sees only its own seven rows, whatever the other rows evaluate to.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Configuration bit is offered |
| cfg_ready | output | 1 | Block accepts a configuration bit |
| cfg_bit | input | 1 | Configuration map bit |
| ded_in | input | 10 | Dedicated array inputs |
| io_in | input | 6 | External value on bidirectional pins 0 to 5 |
| out_val | output | 8 | Inverted OR result per output |
| out_oe | output | 8 | Per-output enable; 0 means high impedance |

## Verification
The assertions rely on two things. First, the configuration stream never offers a bit during reset. Second, the array variable register captures exactly what the dedicated inputs held before each edge. The stimulus meets both: it drives every input on the falling clock edge, and it starts streaming only once `cfg_ready` has risen. The maps the stimulus loads contain only acyclic logic and one set/reset loop, and a latch-clearing input is applied before that loop is relied on. Inputs are then held for several clocks, so every feedback path settles to a single stable value before outputs are compared.

// File: rtl/sop_dev_pkg.sv
`timescale 1ns/1ps
package sop_dev_pkg;
  // Column of a literal inside one product row: true at even, complement at odd.
  function automatic int unsigned lit_col(input int unsigned var_idx, input bit inverted);
    return 2 * var_idx + (inverted ? 1 : 0);
  endfunction
endpackage

// File: rtl/sop_fuse_store.sv
`timescale 1ns/1ps
module sop_fuse_store #(
  parameter int unsigned ROWS = 64,
  parameter int unsigned COLS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_valid,
  input  logic                 cfg_bit,
  output logic                 cfg_ready,
  output logic [ROWS*COLS-1:0] fuse_q
);
  localparam int unsigned NBITS = ROWS * COLS;
  localparam int unsigned AW    = $clog2(NBITS);
  localparam logic [AW-1:0] LAST = AW'(NBITS - 1);

  logic [AW-1:0] wr_ptr;
  logic          take;

  assign take = cfg_valid & cfg_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fuse_q    <= '0;
      wr_ptr    <= '0;
      cfg_ready <= 1'b0;
    end else begin
      cfg_ready <= 1'b1;
      if (take) begin
        fuse_q[wr_ptr] <= cfg_bit;
        wr_ptr         <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      end
    end
  end

  // R2
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && wr_ptr == LAST) |=> (wr_ptr == '0));

  // R2
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(wr_ptr));

  // R2
  bit_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (fuse_q[$past(wr_ptr)] == $past(cfg_bit)));

  // R3
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ready |=> cfg_ready);
endmodule

// File: rtl/sop_term_plane.sv
`timescale 1ns/1ps
module sop_term_plane #(
  parameter int unsigned VARS = 16,
  parameter int unsigned ROWS = 64
) (
  input  logic [VARS-1:0]        vars,
  input  logic [ROWS*2*VARS-1:0] fuse,
  output logic [ROWS-1:0]        term
);
  import sop_dev_pkg::*;
  localparam int unsigned COLS = 2 * VARS;

  logic [COLS-1:0] lits;

  for (genvar v = 0; v < VARS; v++) begin : g_lit
    assign lits[lit_col(v, 1'b0)] = vars[v];
    assign lits[lit_col(v, 1'b1)] = ~vars[v];
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [COLS-1:0] conn;
    assign conn    = fuse[r*COLS +: COLS];
    // an unconnected column contributes 1 to the AND
    assign term[r] = &(~conn | lits);
  end
endmodule

// File: rtl/sop_out_stage.sv
`timescale 1ns/1ps
module sop_out_stage #(
  parameter int unsigned OUT_N = 8,
  parameter int unsigned TERMS = 8
) (
  input  logic [OUT_N*TERMS-1:0] term,
  output logic [OUT_N-1:0]       out_val,
  output logic [OUT_N-1:0]       out_oe
);
  localparam int unsigned SUM_N = TERMS - 1;

  for (genvar i = 0; i < OUT_N; i++) begin : g_out
    logic [SUM_N-1:0] grp;
    assign grp        = term[i*TERMS +: SUM_N];
    assign out_val[i] = ~(|grp);
    assign out_oe[i]  = term[i*TERMS + SUM_N];
  end
endmodule

// File: rtl/prog_sop_device.sv
`timescale 1ns/1ps
module prog_sop_device #(
  parameter int unsigned DED_W = 10,
  parameter int unsigned PIN_W = 6,
  parameter int unsigned OUT_N = 8,
  parameter int unsigned TERMS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_valid,
  output logic             cfg_ready,
  input  logic             cfg_bit,
  input  logic [DED_W-1:0] ded_in,
  input  logic [PIN_W-1:0] io_in,
  output logic [OUT_N-1:0] out_val,
  output logic [OUT_N-1:0] out_oe
);
  localparam int unsigned VARS = DED_W + PIN_W;
  localparam int unsigned COLS = 2 * VARS;
  localparam int unsigned ROWS = OUT_N * TERMS;

  logic [ROWS*COLS-1:0] fuse_q;
  logic [VARS-1:0]      var_q;
  logic [ROWS-1:0]      term;
  logic [PIN_W-1:0]     pin_val;

  sop_fuse_store #(.ROWS(ROWS), .COLS(COLS)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_valid(cfg_valid),
    .cfg_bit  (cfg_bit),
    .cfg_ready(cfg_ready),
    .fuse_q   (fuse_q)
  );

  for (genvar p = 0; p < PIN_W; p++) begin : g_pin
    assign pin_val[p] = out_oe[p] ? out_val[p] : io_in[p];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) var_q <= '0;
    else        var_q <= {pin_val, ded_in};
  end

  sop_term_plane #(.VARS(VARS), .ROWS(ROWS)) u_plane (
    .vars(var_q),
    .fuse(fuse_q),
    .term(term)
  );

  sop_out_stage #(.OUT_N(OUT_N), .TERMS(TERMS)) u_out (
    .term   (term),
    .out_val(out_val),
    .out_oe (out_oe)
  );

  // R8
  ded_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (var_q[DED_W-1:0] == $past(ded_in)));
endmodule

// File: tb/test_prog_sop_device.sv
`timescale 1ns/1ps
module test_prog_sop_device;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_valid = 1'b0;
  logic       cfg_bit = 1'b0;
  logic       cfg_ready;
  logic [9:0] ded_in = '0;
  logic [5:0] io_in = '0;
  logic [7:0] out_val, out_oe;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  prog_sop_device i_prog_sop_device (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_bit(cfg_bit), .ded_in(ded_in), .io_in(io_in),
    .out_val(out_val), .out_oe(out_oe)
  );

  typedef struct {
    logic [7:0] val;
    logic [7:0] oe;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  event smp_ev;

  logic [2047:0] fmap;
  logic [5:0]    mpin = '0;

  function automatic int fidx(input int row, input int v, input bit neg);
    return row * 32 + 2 * v + (neg ? 1 : 0);
  endfunction

  task automatic connect(input int row, input int v, input bit neg);
    fmap[fidx(row, v, neg)] = 1'b1;
  endtask

  task automatic zero_row(input int row);
    connect(row, 0, 1'b0);
    connect(row, 0, 1'b1);
  endtask

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Behavioural model from the requirements; pin state persists across calls.
  task automatic model(input logic [9:0] d, input logic [5:0] io,
                       output logic [7:0] ev, output logic [7:0] eo);
    logic [15:0] vars;
    logic [63:0] t;
    for (int it = 0; it < 12; it++) begin
      vars = {mpin, d};
      for (int r = 0; r < 64; r++) begin
        t[r] = 1'b1;
        for (int v = 0; v < 16; v++) begin
          if (fmap[fidx(r, v, 1'b0)] && !vars[v]) t[r] = 1'b0;
          if (fmap[fidx(r, v, 1'b1)] &&  vars[v]) t[r] = 1'b0;
        end
      end
      for (int o = 0; o < 8; o++) begin
        ev[o] = ~(|t[o*8 +: 7]);
        eo[o] = t[o*8 + 7];
      end
      for (int p = 0; p < 6; p++) mpin[p] = eo[p] ? ev[p] : io[p];
    end
  endtask

  task automatic apply(input logic [9:0] d, input logic [5:0] io, input string req);
    exp_t e;
    @(negedge clk);
    ded_in = d;
    io_in  = io;
    model(d, io, e.val, e.oe);
    e.req = req;
    exp_q.push_back(e);
    repeat (5) @(negedge clk);
    -> smp_ev;
    #0;
  endtask

  initial begin
    forever begin
      exp_t e;
      logic bad;
      @(smp_ev);
      e = exp_q.pop_front();
      bad = (out_oe != e.oe) || (((out_val ^ e.val) & e.oe) != 8'h00);
      check(!bad, e.req, {out_oe, out_val}, {e.oe, e.val});
    end
  end

  task automatic load_map(input bit gaps);
    for (int k = 0; k < 2048; k++) begin
      @(negedge clk);
      if (gaps && (k % 97 == 5)) begin
        cfg_valid = 1'b0;
        cfg_bit   = ~fmap[k];
        @(negedge clk);
      end
      cfg_valid = 1'b1;
      cfg_bit   = fmap[k];
    end
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  initial begin
    #600000;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cfg_ready == 1'b0, "R3 ready low in reset", {15'd0, cfg_ready}, 16'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(cfg_ready == 1'b1, "R3 ready after reset", {15'd0, cfg_ready}, 16'd1);
    check(out_val == 8'h00 && out_oe == 8'hFF, "R9 reset outputs",
          {out_oe, out_val}, 16'hFF00);

    // map A
    fmap = '0;
    connect(0, 0, 0); connect(0, 1, 0); connect(1, 2, 1);
    for (int r = 2; r <= 6; r++) zero_row(r);
    zero_row(15);
    connect(16, 11, 0); for (int r = 17; r <= 22; r++) zero_row(r);
    connect(24, 10, 0); for (int r = 25; r <= 30; r++) zero_row(r);
    connect(32, 6, 0); connect(33, 5, 1); connect(33, 14, 1);
    for (int r = 34; r <= 38; r++) zero_row(r);
    for (int r = 40; r <= 46; r++) zero_row(r);
    connect(48, 3, 0); for (int r = 49; r <= 54; r++) zero_row(r); connect(55, 4, 0);
    load_map(1'b0);

    apply(10'b0001000000, 6'b000000, "R4 latch clear");
    apply(10'b0000000111, 6'b000000, "R1 R5 out0 AND term");
    apply(10'b0000000011, 6'b000001, "R5 R7 inverted OR, io0 ignored");
    apply(10'b0000000001, 6'b000000, "R1 complement literal");
    apply(10'b0000000100, 6'b000010, "R7 input-only pin feeds array");
    apply(10'b0000000100, 6'b000000, "R7 input-only pin low");
    apply(10'b0000100000, 6'b000000, "R8 feedback set");
    apply(10'b0000000000, 6'b000000, "R8 feedback hold high");
    apply(10'b0001000000, 6'b000000, "R8 feedback reset");
    apply(10'b0000000000, 6'b010000, "R8 feedback hold low");
    apply(10'b0000011000, 6'b000000, "R6 enable term high");
    apply(10'b0000001000, 6'b000000, "R6 enable term low");
    @(negedge clk);
    check(out_val[5] == 1'b1 && out_oe[5], "R10 private terms", {14'd0, out_oe[5], out_val[5]}, 16'd3);
    check(out_oe[1] == 1'b0, "R6 R4 constant-0 enable", {15'd0, out_oe[1]}, 16'd0);

    // R8: one edge from input to feedback-free output
    ded_in = 10'b0000010000;
    #1;
    check(out_val[6] == 1'b0, "R8 no change before edge", {15'd0, out_val[6]}, 16'd0);
    @(negedge clk);
    check(out_val[6] == 1'b1 && out_oe[6], "R8 change after one edge", {14'd0, out_oe[6], out_val[6]}, 16'd3);

    // map B with stream gaps; second load also exercises pointer wrap
    fmap = '0;
    connect(56, 9, 0); connect(56, 8, 1);
    for (int r = 57; r <= 62; r++) zero_row(r);
    connect(63, 7, 1);
    load_map(1'b1);
    apply(10'b1000000000, 6'b000000, "R2 gapped load, wrap");
    apply(10'b1100000000, 6'b000000, "R2 R5 map B term off");
    apply(10'b1010000000, 6'b000000, "R2 R6 map B disabled");
    apply(10'b0000000000, 6'b111111, "R2 map B blank outputs");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2 scoreboard drained", 16'(exp_q.size()), 16'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule